// File: doc/BRIEF.md
# DSP Pointer Address Generator

This block generates memory addresses for a signal-processing datapath. It holds five 16-bit pointer registers: four general pointers P0 to P3 and a stack pointer. It also holds a signed step register and a wrap-control register.

On each access request the block picks one pointer and drives that pointer's current value as the effective address in the same cycle. When updating is enabled, it then writes the pointer plus the signed step back into the same pointer at the clock edge. This post-step costs no extra cycle. The next access therefore sees the new value.

Pointers P0 and P1 can run as circular buffers. When the wrap-control register holds a value M between 1 and 7FFF hex, these two pointers step modulo M+1 inside an aligned window. The other three pointers always step linearly, and so do P0 and P1 when the wrap-control register holds any other value.

A register-write port loads any pointer, the step register or the wrap-control register. The access port has no back-pressure. A request is taken in every cycle it is valid, and `ea_valid` simply mirrors it. Both ports are plain control pins.

Top module: `agu_core`

## Requirements
- R1: After reset every pointer and the step register read as 0000 hex, and the wrap-control register holds FFFF hex (linear).
- R2: While `acc_valid` is high, `ea` equals the selected pointer's value before any update, combinationally in the same cycle, and `ea_valid` equals `acc_valid`; `ea` is 0 when `acc_valid` is low.
- R3: An access with `acc_upd` high leaves the selected pointer holding its old value plus the step after the next rising clock edge.
- R4: The step register is a 16-bit two's-complement value, so values 8000 to FFFF hex move the pointer downwards.
- R5: Accesses never change the step register or the wrap-control register.
- R6: Pointers P2, P3 and SP (select codes 2, 3, 4) always step linearly modulo 2^16 (FFFE + 4 gives 0002), whatever the wrap-control register holds.
- R7: For P0 and P1 (select codes 0, 1), with wrap control M in 0001..7FFF hex, the window base is the pointer with its low ceil(log2(M+1)) bits cleared. A stepped value above base+M has M+1 subtracted, and one below base has M+1 added. This holds for |step| <= M+1.
- R8: Wrap control 0000 hex or any value 8000..FFFF hex makes P0 and P1 step linearly.
- R9: A register write to a pointer in the same cycle as an update of that pointer wins; the written value is stored.
- R10: An access with `acc_upd` low (plain indirect) leaves the pointer unchanged.
- R11: Write select codes are 0..3 for P0..P3, 4 for SP, 5 for the step, 6 for wrap control; code 7 writes nothing. Access select codes 5..7 drive `ea` to 0 and update nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register write target code |
| wr_data | input | 16 | Register write value |
| acc_valid | input | 1 | Access request, taken every cycle it is high |
| acc_sel | input | 3 | Pointer select for the access |
| acc_upd | input | 1 | Apply post-step after the access |
| ea | output | 16 | Effective address (pre-update pointer) |
| ea_valid | output | 1 | Effective address valid |

## Verification
The bench builds the block at the default width of 16 bits. At that width the linear wrap past FFFF hex and the sign of the step both fall on the real 16-bit boundaries, so a single carry or sign error shows up directly in `ea`. Choosing the wrap-control value from 0000, 8000..FFFE, FFFF and a mix of power-of-two and other moduli puts every arithmetic mode and both wrap directions within reach. Random traffic also hits same-cycle write and update collisions on every pointer.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int unsigned SEL_W = 3;
  localparam int unsigned NPTR  = 5;
  localparam int unsigned NMOD  = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_P0   = 3'd0,
    SEL_P1   = 3'd1,
    SEL_P2   = 3'd2,
    SEL_P3   = 3'd3,
    SEL_SP   = 3'd4,
    SEL_STEP = 3'd5,
    SEL_WRAP = 3'd6,
    SEL_NONE = 3'd7
  } sel_e;
endpackage

// File: rtl/agu_step.sv
// Next-pointer arithmetic: linear, or circular when MOD_CAP is set and
// the wrap-control value lies in 1 .. 2^(AW-1)-1.
module agu_step #(
  parameter int unsigned AW      = 16,
  parameter bit          MOD_CAP = 1'b0
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] wrap,
  output logic [AW-1:0] nxt
);
  localparam int unsigned XW = AW + 2;

  logic [AW-1:0] lin;
  assign lin = ptr + step;

  generate
    if (MOD_CAP) begin : g_mod
      logic                 mod_on;
      logic [AW-1:0]        span_mask;
      logic [AW-1:0]        base;
      logic [AW-1:0]        top;
      logic signed [XW-1:0] sum_x;
      logic signed [XW-1:0] base_x;
      logic signed [XW-1:0] top_x;
      logic signed [XW-1:0] len_x;
      logic signed [XW-1:0] wrapped;

      assign mod_on = (wrap != '0) && !wrap[AW-1];

      // every bit at or below the top set bit of wrap
      always_comb begin
        for (int i = 0; i < AW; i++) begin
          span_mask[i] = |(wrap >> i);
        end
      end

      assign base   = ptr & ~span_mask;
      assign top    = base | wrap;
      assign sum_x  = $signed({2'b00, ptr}) + $signed({{2{step[AW-1]}}, step});
      assign base_x = $signed({2'b00, base});
      assign top_x  = $signed({2'b00, top});
      assign len_x  = $signed({2'b00, wrap}) + $signed(XW'(1));

      always_comb begin
        if (sum_x > top_x)       wrapped = sum_x - len_x;
        else if (sum_x < base_x) wrapped = sum_x + len_x;
        else                     wrapped = sum_x;
      end

      assign nxt = mod_on ? wrapped[AW-1:0] : lin;
    end else begin : g_lin
      logic unused_wrap;
      assign unused_wrap = ^wrap;
      assign nxt = lin;
    end
  endgenerate
endmodule

// File: rtl/agu_ptr_reg.sv
// One pointer register; a direct write takes priority over a post-step.
module agu_ptr_reg #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hit,
  input  logic [AW-1:0] wr_data,
  input  logic          upd_hit,
  input  logic [AW-1:0] upd_val,
  output logic [AW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (wr_hit)  q <= wr_data;
    else if (upd_hit) q <= upd_val;
  end
endmodule

// File: rtl/agu_core.sv
module agu_core #(
  parameter int unsigned AW = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [agu_pkg::SEL_W-1:0]  wr_sel,
  input  logic [AW-1:0]              wr_data,
  input  logic                       acc_valid,
  input  logic [agu_pkg::SEL_W-1:0]  acc_sel,
  input  logic                       acc_upd,
  output logic [AW-1:0]              ea,
  output logic                       ea_valid
);
  import agu_pkg::*;

  localparam int unsigned NP = NPTR;

  logic [AW-1:0]    ofs_q;
  logic [AW-1:0]    mod_q;
  logic [NP*AW-1:0] ptr_flat;

  // step and wrap-control registers; only the write port touches them
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q <= '0;
      mod_q <= '1;
    end else if (wr_en) begin
      if (wr_sel == SEL_STEP) ofs_q <= wr_data;
      if (wr_sel == SEL_WRAP) mod_q <= wr_data;
    end
  end

  generate
    for (genvar i = 0; i < NP; i++) begin : g_ptr
      logic          wr_hit;
      logic          upd_hit;
      logic [AW-1:0] cur;
      logic [AW-1:0] nxt;

      assign wr_hit  = wr_en && (wr_sel == SEL_W'(i));
      assign upd_hit = acc_valid && acc_upd && (acc_sel == SEL_W'(i));

      agu_step #(
        .AW      (AW),
        .MOD_CAP (i < NMOD)
      ) u_step (
        .ptr  (cur),
        .step (ofs_q),
        .wrap (mod_q),
        .nxt  (nxt)
      );

      agu_ptr_reg #(
        .AW (AW)
      ) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_hit),
        .wr_data (wr_data),
        .upd_hit (upd_hit),
        .upd_val (nxt),
        .q       (cur)
      );

      assign ptr_flat[i*AW +: AW] = cur;
    end
  endgenerate

  always_comb begin
    ea = '0;
    if (acc_valid) begin
      for (int i = 0; i < int'(NP); i++) begin
        if (acc_sel == SEL_W'(i)) ea = ptr_flat[i*AW +: AW];
      end
    end
  end

  assign ea_valid = acc_valid;
endmodule

// File: rtl/agu_core_chk.sv
module agu_core_chk #(
  parameter int unsigned AW = 16
) (
  input logic                                   clk,
  input logic                                   rst_n,
  input logic                                   wr_en,
  input logic [agu_pkg::SEL_W-1:0]              wr_sel,
  input logic [AW-1:0]                          wr_data,
  input logic                                   acc_valid,
  input logic [agu_pkg::SEL_W-1:0]              acc_sel,
  input logic                                   acc_upd,
  input logic [AW-1:0]                          ea,
  input logic                                   ea_valid,
  input logic [agu_pkg::NPTR*AW-1:0]            ptr_flat,
  input logic [AW-1:0]                          ofs_q,
  input logic [AW-1:0]                          mod_q
);
  import agu_pkg::*;

  function automatic logic [AW-1:0] ptr_at(input logic [SEL_W-1:0] s);
    logic [AW-1:0] v;
    v = '0;
    for (int i = 0; i < int'(NPTR); i++) begin
      if (s == SEL_W'(i)) v = ptr_flat[i*AW +: AW];
    end
    return v;
  endfunction

  logic              sel_ok;
  logic              same_wr;
  logic              pend_wr;
  logic [SEL_W-1:0]  pend_wr_sel;
  logic [AW-1:0]     pend_wr_val;
  logic              pend_hold;
  logic              pend_lin;
  logic [SEL_W-1:0]  pend_sel;
  logic [AW-1:0]     pend_val;

  assign sel_ok  = acc_sel < SEL_W'(NPTR);
  assign same_wr = wr_en && (wr_sel == acc_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_wr     <= 1'b0;
      pend_wr_sel <= '0;
      pend_wr_val <= '0;
      pend_hold   <= 1'b0;
      pend_lin    <= 1'b0;
      pend_sel    <= '0;
      pend_val    <= '0;
    end else begin
      pend_wr     <= wr_en && (wr_sel < SEL_W'(NPTR));
      pend_wr_sel <= wr_sel;
      pend_wr_val <= wr_data;
      pend_hold   <= acc_valid && !acc_upd && sel_ok && !same_wr;
      pend_lin    <= acc_valid && acc_upd && sel_ok && !same_wr &&
                     (acc_sel >= SEL_W'(NMOD));
      pend_sel    <= acc_sel;
      pend_val    <= acc_upd ? (ea + ofs_q) : ea;
    end
  end

  a_r2_ea_pre_update: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && sel_ok) |-> (ea == ptr_at(acc_sel) && ea_valid));

  a_r11_ea_zero_bad_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !sel_ok) |-> (ea == '0));

  a_r5_step_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == SEL_STEP) |=> $stable(ofs_q));

  a_r5_wrap_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == SEL_WRAP) |=> $stable(mod_q));

  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    pend_wr |-> (ptr_at(pend_wr_sel) == pend_wr_val));

  a_r10_plain_holds: assert property (@(posedge clk) disable iff (!rst_n)
    pend_hold |-> (ptr_at(pend_sel) == pend_val));

  a_r6_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    pend_lin |-> (ptr_at(pend_sel) == pend_val));
endmodule

bind agu_core agu_core_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .acc_valid (acc_valid),
  .acc_sel   (acc_sel),
  .acc_upd   (acc_upd),
  .ea        (ea),
  .ea_valid  (ea_valid),
  .ptr_flat  (ptr_flat),
  .ofs_q     (ofs_q),
  .mod_q     (mod_q)
);

// File: tb/sim_agu_core.sv
module sim_agu_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        acc_valid = 1'b0;
  logic [2:0]  acc_sel = '0;
  logic        acc_upd = 1'b0;
  logic [15:0] ea;
  logic        ea_valid;

  int checks = 0;
  int fails  = 0;

  logic [15:0] mp [5];
  logic [15:0] mstep;
  logic [15:0] mwrap;

  always #(CLK_PERIOD/2) clk = ~clk;

  agu_core u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .acc_valid(acc_valid), .acc_sel(acc_sel), .acc_upd(acc_upd),
    .ea(ea), .ea_valid(ea_valid)
  );

  function automatic logic [15:0] ref_next(int s, logic [15:0] p, logic [15:0] n, logic [15:0] m);
    int sum, base, len, pw;
    sum = int'(p) + int'($signed(n));
    if (s < 2 && m != 16'h0000 && m < 16'h8000) begin
      len = int'(m) + 1;
      pw = 1;
      while (pw < len) pw = pw * 2;
      base = int'(p) & ~(pw - 1);
      if (sum > base + int'(m)) sum = sum - len;
      else if (sum < base)      sum = sum + len;
    end
    return sum[15:0];
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive, check ea mid-cycle, advance the model
  task automatic cyc(string req, bit we, logic [2:0] ws, logic [15:0] wd,
                     bit av, logic [2:0] as, bit au);
    logic [15:0] exp_ea;
    @(negedge clk);
    wr_en = we; wr_sel = ws; wr_data = wd;
    acc_valid = av; acc_sel = as; acc_upd = au;
    #1;
    exp_ea = (av && as < 3'd5) ? mp[as] : 16'h0000;
    check(req, ea, exp_ea);
    check(req, {15'd0, ea_valid}, {15'd0, av});
    if (av && au && as < 3'd5) mp[as] = ref_next(int'(as), mp[as], mstep, mwrap);
    if (we) begin
      if (ws < 3'd5)       mp[ws] = wd;
      else if (ws == 3'd5) mstep = wd;
      else if (ws == 3'd6) mwrap = wd;
    end
  endtask

  task automatic wr(logic [2:0] s, logic [15:0] d);
    cyc("R11", 1'b1, s, d, 1'b0, 3'd0, 1'b0);
  endtask

  task automatic acc(string req, logic [2:0] s, bit u);
    cyc(req, 1'b0, 3'd0, 16'h0, 1'b1, s, u);
  endtask

  task automatic expect_ptr(string req, logic [2:0] s, logic [15:0] v);
    @(negedge clk);
    wr_en = 1'b0; acc_valid = 1'b1; acc_sel = s; acc_upd = 1'b0;
    #1;
    check(req, ea, v);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 5; i++) mp[i] = 16'h0000;
    mstep = 16'h0000;
    mwrap = 16'hFFFF;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1: reset state
    for (int i = 0; i < 5; i++) expect_ptr("R1", 3'(i), 16'h0000);
    acc("R1", 3'd2, 1'b1);
    expect_ptr("R1", 3'd2, 16'h0000);
    wr(3'd0, 16'h0006); wr(3'd5, 16'h0004);
    acc("R1", 3'd0, 1'b1);
    expect_ptr("R1", 3'd0, 16'h000A);

    // R2/R3: basic post-step
    wr(3'd2, 16'h3200);
    wr(3'd6, 16'hFFFF);
    acc("R2", 3'd2, 1'b1);
    expect_ptr("R3", 3'd2, 16'h3204);
    // R10: plain indirect keeps pointer
    acc("R10", 3'd2, 1'b0);
    expect_ptr("R10", 3'd2, 16'h3204);
    // R5: step unchanged by accesses
    acc("R5", 3'd2, 1'b1);
    expect_ptr("R5", 3'd2, 16'h3208);
    // R4: negative step
    wr(3'd5, 16'hFFFC); wr(3'd3, 16'h0010);
    acc("R4", 3'd3, 1'b1);
    expect_ptr("R4", 3'd3, 16'h000C);
    // R6: linear wrap and wrap control ignored on P2
    wr(3'd5, 16'h0004); wr(3'd4, 16'hFFFE);
    acc("R6", 3'd4, 1'b1);
    expect_ptr("R6", 3'd4, 16'h0002);
    wr(3'd6, 16'h0007); wr(3'd5, 16'h0003); wr(3'd2, 16'h1006);
    acc("R6", 3'd2, 1'b1);
    expect_ptr("R6", 3'd2, 16'h1009);
    // R7: circular P0/P1 both directions and non power of two
    wr(3'd0, 16'h1006);
    acc("R7", 3'd0, 1'b1);
    expect_ptr("R7", 3'd0, 16'h1001);
    wr(3'd5, 16'hFFFD); wr(3'd1, 16'h1001);
    acc("R7", 3'd1, 1'b1);
    expect_ptr("R7", 3'd1, 16'h1006);
    wr(3'd6, 16'h0004); wr(3'd5, 16'h0002); wr(3'd0, 16'h2004);
    acc("R7", 3'd0, 1'b1);
    expect_ptr("R7", 3'd0, 16'h2001);
    // R5: wrap control survives accesses
    acc("R5", 3'd0, 1'b1);
    expect_ptr("R5", 3'd0, 16'h2003);
    // R8: linear for 0000, 8000 and FFFE
    wr(3'd5, 16'h0003);
    wr(3'd6, 16'h0000); wr(3'd0, 16'h1006);
    acc("R8", 3'd0, 1'b1);
    expect_ptr("R8", 3'd0, 16'h1009);
    wr(3'd6, 16'h8000); wr(3'd1, 16'h1006);
    acc("R8", 3'd1, 1'b1);
    expect_ptr("R8", 3'd1, 16'h1009);
    wr(3'd6, 16'hFFFE); wr(3'd0, 16'h1006);
    acc("R8", 3'd0, 1'b1);
    expect_ptr("R8", 3'd0, 16'h1009);
    // R9: write wins over same-pointer update
    cyc("R9", 1'b1, 3'd1, 16'h5555, 1'b1, 3'd1, 1'b1);
    expect_ptr("R9", 3'd1, 16'h5555);
    // R11: select 7 writes nothing, bad access select gives zero
    cyc("R11", 1'b1, 3'd7, 16'hBEEF, 1'b1, 3'd6, 1'b1);
    for (int i = 0; i < 5; i++) acc("R11", 3'(i), 1'b0);
    acc("R11", 3'd5, 1'b1);
    cyc("R2", 1'b0, 3'd0, 16'h0, 1'b0, 3'd1, 1'b1);

    // constrained random traffic
    wr(3'd6, 16'h00FF);
    wr(3'd5, 16'h0001);
    for (int k = 0; k < 4000; k++) begin
      int r, n;
      logic [15:0] m;
      r = int'($urandom_range(0, 99));
      if (r < 8) begin
        wr(3'($urandom_range(0, 4)), 16'($urandom));
      end else if (r < 12) begin
        n = int'($urandom_range(0, 32)) - 16;
        wr(3'd5, 16'(n));
      end else if (r < 15) begin
        case ($urandom_range(0, 4))
          0: m = 16'h0000;
          1: m = 16'hFFFF;
          2: m = 16'h8000 | 16'($urandom_range(0, 16'h7FFE));
          3: m = 16'($urandom_range(15, 255));
          default: m = 16'h003F;
        endcase
        wr(3'd6, m);
      end else if (r < 22) begin
        cyc("R9", 1'b1, 3'($urandom_range(0, 4)), 16'($urandom),
            1'b1, 3'($urandom_range(0, 4)), 1'b1);
      end else begin
        cyc("R7", 1'b0, 3'd0, 16'h0, 1'($urandom_range(0, 9) != 0),
            3'($urandom_range(0, 7)), 1'($urandom_range(0, 3) != 0));
      end
    end

    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule